// File: doc/BRIEF.md
# Dot and Row Polarity Inversion Controller

This block sits between the display-data latches and the grayscale voltage decoders of a column driver. For each of its column outputs it takes the 6-bit grayscale code held for that column and adds one polarity bit. The decoder uses that bit to pick between the positive set of 64 levels, in the upper half of the drive supply, and the negative set, in the lower half. The 7-bit selection for every column is registered on the line strobe.

Polarity alternates from pin to pin, which gives dot inversion. A row phase flips the whole pattern once every N raster rows, with N taken from a 4-bit input. An alternation input inverts every pin at once. A frame-start pulse returns the row phase to a known state, so every frame begins with the same polarity pattern. The phase is held in a two-state machine. Its states are `PHASE_EVEN` and `PHASE_ODD`. It has three named transitions:

- FLIP: when a line strobe arrives and the row counter sits at its last row, the machine moves to the other state.
- REST: when a frame-start pulse arrives, the machine goes to `PHASE_EVEN` from either state.
- HOLD: in every other cycle the machine stays in its current state.

Top module: `polarity_select`

## Requirements
- R1: After reset every bit of `sel_o` is 0, the row phase is even (0) and the row counter is 0.
- R2: In a cycle where `line_stb` is low, `sel_o` keeps its value.
- R3: On a clock edge with `line_stb` high, bits [7k+5:7k] of `sel_o` take the code of pin k, which is `codes[6k+5:6k]`. The new value is visible from the following cycle.
- R4: On the same edge, bit 7k+6 of `sel_o` (the polarity, 1 = negative range) takes phase XOR alt XOR k[0]. Adjacent pins therefore always get opposite polarity.
- R5: With `alt` high at the strobe, every polarity bit is the inverse of the value it would take with `alt` low.
- R6: Counted from a frame start, strobed rows 0..N-1 use phase 0, rows N..2N-1 use phase 1, and so on. The phase flips after every N strobes.
- R7: An `n_rows` value of 0 behaves exactly like 1, so the phase flips on every strobe.
- R8: A `frame_start` pulse clears the row counter and sets the phase to 0. It takes priority over a strobe in the same cycle, and that strobe still latches using the phase in force before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_stb | input | 1 | One-cycle line strobe; latches outputs and advances the row counter |
| frame_start | input | 1 | One-cycle frame start; clears the row counter and phase |
| alt | input | 1 | Global polarity swap, sampled at the strobe |
| n_rows | input | 4 | Rows per inversion period (0 treated as 1) |
| codes | input | 2304 | 384 grayscale codes, 6 bits each, pin k at [6k+5:6k] |
| sel_o | output | 2688 | 384 selections, 7 bits each: {polarity, code} at [7k+6:7k] |

## Verification
Every result of this block is due one clock after the rising edge that sees `line_stb` high. The lane registers capture on that edge, and `sel_o` is stable from then on. The bench drives its inputs on falling edges and records which rising edge carried a strobe. It pops the expected selection vector on the falling edge half a cycle after that strobe edge, so each comparison lands on the first cycle the new value exists. A frame-start pulse changes no output by itself; its effect appears in the polarity of the next strobed row.

// File: rtl/pol_pkg.sv
package pol_pkg;
    typedef enum logic {
        PHASE_EVEN = 1'b0,
        PHASE_ODD  = 1'b1
    } phase_e;
endpackage

// File: rtl/row_phase_fsm.sv
module row_phase_fsm
    import pol_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_stb,
    input  logic             frame_start,
    input  logic [CNT_W-1:0] n_rows,
    output phase_e           phase_o
);
    phase_e           state, nxt;
    logic [CNT_W-1:0] row_cnt, row_cnt_nxt;
    logic [CNT_W-1:0] last_row;
    logic             at_last;

    // n_rows of 0 is treated as 1, so the last row index is 0
    always_comb begin
        last_row = (n_rows == '0) ? '0 : n_rows - 1'b1;
        at_last  = (row_cnt >= last_row);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= PHASE_EVEN;
            row_cnt <= '0;
        end else begin
            state   <= nxt;
            row_cnt <= row_cnt_nxt;
        end
    end

    always_comb begin
        nxt         = state;
        row_cnt_nxt = row_cnt;
        unique case (state)
            PHASE_EVEN: begin
                if (frame_start) nxt = PHASE_EVEN;
                else if (line_stb && at_last) nxt = PHASE_ODD;
            end
            PHASE_ODD: begin
                if (frame_start) nxt = PHASE_EVEN;
                else if (line_stb && at_last) nxt = PHASE_EVEN;
            end
        endcase
        if (frame_start) row_cnt_nxt = '0;
        else if (line_stb) row_cnt_nxt = at_last ? '0 : row_cnt + 1'b1;
    end

    assign phase_o = state;

    // R8
    frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (state == PHASE_EVEN) && (row_cnt == '0));

    // R6
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_stb && !frame_start) |=> $stable(state) && $stable(row_cnt));

    // R6
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && !frame_start && at_last) |=> (state != $past(state)) && (row_cnt == '0));

    // R7
    n_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && !frame_start && n_rows == '0) |=> state != $past(state));
endmodule

// File: rtl/pol_lane.sv
module pol_lane #(
    parameter int       CODE_W  = 6,
    parameter bit       PIN_ODD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              phase_bit,
    input  logic              alt,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W:0]   sel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel <= '0;
        else if (load) sel <= {phase_bit ^ alt ^ PIN_ODD, code};
    end
endmodule

// File: rtl/polarity_select.sv
module polarity_select
    import pol_pkg::*;
#(
    parameter int NUM_OUT = 384,
    parameter int CODE_W  = 6,
    parameter int CNT_W   = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           line_stb,
    input  logic                           frame_start,
    input  logic                           alt,
    input  logic [CNT_W-1:0]               n_rows,
    input  logic [NUM_OUT*CODE_W-1:0]      codes,
    output logic [NUM_OUT*(CODE_W+1)-1:0]  sel_o
);
    localparam int SEL_W = CODE_W + 1;

    phase_e phase;

    row_phase_fsm #(.CNT_W(CNT_W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_stb    (line_stb),
        .frame_start (frame_start),
        .n_rows      (n_rows),
        .phase_o     (phase)
    );

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_lane
        pol_lane #(.CODE_W(CODE_W), .PIN_ODD(k % 2 == 1)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (line_stb),
            .phase_bit (phase == PHASE_ODD),
            .alt       (alt),
            .code      (codes[k*CODE_W +: CODE_W]),
            .sel       (sel_o[k*SEL_W +: SEL_W])
        );
    end

    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stb |=> $stable(sel_o));

    // R3
    code_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_stb |=> sel_o[CODE_W-1:0] == $past(codes[CODE_W-1:0]));

    // R4
    adj_opposite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_stb |=> sel_o[SEL_W-1] != sel_o[2*SEL_W-1]);

    // R5
    alt_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_stb |=> sel_o[SEL_W-1] == ($past(alt) ^ $past(phase == PHASE_ODD)));
endmodule

// File: tb/sim_polarity_select.sv
module sim_polarity_select;
    localparam int CLK_P   = 10;
    localparam int NUM_OUT = 384;
    localparam int CODE_W  = 6;
    localparam int SEL_W   = CODE_W + 1;
    localparam int TOT_W   = NUM_OUT * SEL_W;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic                        line_stb = 1'b0;
    logic                        frame_start = 1'b0;
    logic                        alt = 1'b0;
    logic [3:0]                  n_rows = 4'd1;
    logic [NUM_OUT*CODE_W-1:0]   codes = '0;
    logic [TOT_W-1:0]            sel_o;

    int total = 0;
    int bad = 0;

    logic [TOT_W-1:0] exp_q[$];
    string            tag_q[$];
    logic [TOT_W-1:0] last_exp = '0;
    logic             pend = 1'b0;

    int m_cnt = 0;
    int m_ph  = 0;

    always #(CLK_P/2) clk = ~clk;

    polarity_select u0 (
        .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .frame_start(frame_start),
        .alt(alt), .n_rows(n_rows), .codes(codes), .sel_o(sel_o)
    );

    always @(posedge clk) pend <= line_stb;

    task automatic report(input string tag, input logic [TOT_W-1:0] got, input logic [TOT_W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            for (int k = 0; k < NUM_OUT; k++) begin
                if (got[k*SEL_W +: SEL_W] !== exp[k*SEL_W +: SEL_W]) begin
                    $display("FAIL %s pin %0d got=%h exp=%h", tag, k,
                             got[k*SEL_W +: SEL_W], exp[k*SEL_W +: SEL_W]);
                    break;
                end
            end
        end
    endtask

    // monitor: result due one cycle after the strobe edge
    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            logic [TOT_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            report(t, sel_o, e);
        end
    end

    task automatic drive_line(input logic a, input bit fs, input int seed, input string tag);
        logic [TOT_W-1:0] e;
        int neff;
        @(negedge clk);
        for (int k = 0; k < NUM_OUT; k++) begin
            logic [5:0] c;
            c = 6'((k * 7 + seed * 13 + k / 5) & 63);
            codes[k*CODE_W +: CODE_W] = c;
            e[k*SEL_W +: SEL_W] = {1'(m_ph[0] ^ a ^ k[0]), c};
        end
        alt = a;
        line_stb = 1'b1;
        frame_start = fs;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_exp = e;
        neff = (n_rows == 0) ? 1 : int'(n_rows);
        if (fs) begin
            m_cnt = 0; m_ph = 0;
        end else if (m_cnt >= neff - 1) begin
            m_cnt = 0; m_ph ^= 1;
        end else begin
            m_cnt++;
        end
        @(negedge clk);
        line_stb = 1'b0;
        frame_start = 1'b0;
    endtask

    task automatic new_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        m_cnt = 0; m_ph = 0;
    endtask

    initial begin
        #(CLK_P * 20000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        report("R1 reset", sel_o, '0);

        // R4 R6: N=1, dot pattern flips every row
        n_rows = 4'd1;
        new_frame();
        for (int i = 0; i < 6; i++) drive_line(1'b0, 1'b0, i, "R4 R6 n1");

        // R3 R6: N=2
        n_rows = 4'd2;
        new_frame();
        for (int i = 0; i < 8; i++) drive_line(1'b0, 1'b0, 20 + i, "R3 R6 n2");

        // R5 R6: N=3 with alt toggling
        n_rows = 4'd3;
        new_frame();
        for (int i = 0; i < 9; i++) drive_line(1'(i % 2), 1'b0, 40 + i, "R5 R6 n3");

        // R2: idle cycles keep outputs
        repeat (4) @(negedge clk);
        report("R2 hold", sel_o, last_exp);

        // R6: second frame of N=3 restarts at phase 0
        new_frame();
        for (int i = 0; i < 7; i++) drive_line(1'b0, 1'b0, 60 + i, "R6 n3 frame2");

        // R7: N=0 behaves as 1
        n_rows = 4'd0;
        new_frame();
        for (int i = 0; i < 5; i++) drive_line(1'b1, 1'b0, 80 + i, "R7 n0");

        // R8: frame start coincident with strobe, then rows after the clear
        n_rows = 4'd2;
        drive_line(1'b0, 1'b0, 90, "R8 pre");
        drive_line(1'b0, 1'b1, 91, "R8 coincident");
        for (int i = 0; i < 5; i++) drive_line(1'b0, 1'b0, 92 + i, "R8 after");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            bad++; total++;
            $display("FAIL R3 pending results got=%0d exp=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule